// File: doc/BRIEF.md
# Strongly Ordered Access Gate

This block sits between a processor core's load/store issue point and its memory port. It enforces strict ordering on a small set of requests. Normal loads and stores pass straight through, and a counter tracks how many are still waiting for a response. A request tagged with the strongly-ordered page attribute is captured once. It is then held until every earlier normal access has drained. After that it is sent to memory alone, marked non-cacheable and shared, and no later request of any kind is accepted until its response arrives.

Two further request kinds share the same request channel: barrier requests and interrupt-mask-update requests. Neither is granted while a strongly-ordered access is captured or outstanding. Both are granted in the cycle they are presented once the gate is free again, so the core simply stalls on the request handshake. Every transaction sent to memory also carries a flag telling whether its byte range crosses a 4 KB boundary.

Top module: `so_order_gate`

## Requirements
- R1: While the gate is free, a normal access (`req_kind` = 0, `req_so` = 0) appears on the memory port in the same cycle. Address, size and direction are unchanged, and `mem_nc` and `mem_shared` are low. It is accepted exactly when `mem_ready` is high and the outstanding counter is not full.
- R2: A strongly-ordered access (`req_kind` = 0, `req_so` = 1) is accepted in one cycle when the gate is free. Nothing is then sent to memory until the count of normal accesses that were issued but not yet answered has reached zero.
- R3: The captured strongly-ordered access is presented with its original address, size (bytes = 2^`req_size`) and direction, with `mem_nc` = 1 and `mem_shared` = 1. It stays presented until `mem_ready` is high. After that handshake it is never presented again.
- R4: From the acceptance of a strongly-ordered access until the cycle after its completion, `req_ready` is low for every request kind.
- R5: The first `rsp_valid` after the strongly-ordered handshake completes it, whether that response is read data or a write acknowledge. The gate accepts requests again in the following cycle.
- R6: A barrier request (`req_kind` = 1) is accepted, with a one-cycle `barrier_done` pulse, only while no strongly-ordered access is captured or outstanding.
- R7: An interrupt-mask update (`req_kind` = 2) is accepted, with a one-cycle `mask_grant` pulse, under the same condition as R6.
- R8: `mem_xcross` is high on a presented transaction exactly when (address mod 4096) + 2^size > 4096.
- R9: At most 2^CNT_W − 1 normal accesses are outstanding. At that count, further normal accesses are stalled rather than issued.
- R10: Reset returns the gate to the free state with a zero count. Any captured or in-flight strongly-ordered access is dropped and never presented again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core presents a request |
| req_ready | output | 1 | Request taken this cycle; low means the core stalls |
| req_kind | input | 2 | 0 access, 1 barrier, 2 interrupt-mask update |
| req_so | input | 1 | Strongly-ordered page attribute of an access |
| req_write | input | 1 | Access is a store |
| req_size | input | 2 | Access size, 2^size bytes |
| req_addr | input | ADDR_W | Access byte address |
| mem_valid | output | 1 | Transaction presented to memory |
| mem_ready | input | 1 | Memory takes the transaction |
| mem_addr | output | ADDR_W | Transaction address |
| mem_size | output | 2 | Transaction size |
| mem_write | output | 1 | Transaction is a store |
| mem_nc | output | 1 | Bypass caches |
| mem_shared | output | 1 | Shared attribute on the bus |
| mem_xcross | output | 1 | Byte range crosses a 4 KB boundary |
| rsp_valid | input | 1 | Read data returned or write acknowledged |
| barrier_done | output | 1 | Barrier request completed |
| mask_grant | output | 1 | Interrupt-mask update allowed |

## Verification
The hardest case to reach is a strongly-ordered access that arrives while the outstanding counter is full, followed by a barrier and a mask update queued behind it. The stimulus alternates long stretches of slow responses with stretches of fast ones, so the counter repeatedly saturates and then drains while strongly-ordered requests are interleaved. A reset is also applied deliberately while a strongly-ordered access is waiting for its response, to show that it is never presented again.

// File: rtl/so_gate_pkg.sv
package so_gate_pkg;

  typedef enum logic [1:0] {
    K_ACCESS  = 2'd0,
    K_BARRIER = 2'd1,
    K_MASKUPD = 2'd2,
    K_RSVD    = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    S_FREE  = 2'd0,
    S_DRAIN = 2'd1,
    S_ISSUE = 2'd2,
    S_WAIT  = 2'd3
  } gate_state_e;

  localparam int unsigned PAGE_BYTES = 4096;

  // Byte range [off, off + 2^sz) leaves the current 4 KB page.
  function automatic logic crosses_page(input logic [11:0] off, input logic [1:0] sz);
    logic [12:0] end_excl;
    end_excl = {1'b0, off} + (13'd1 << sz);
    return end_excl > 13'(PAGE_BYTES);
  endfunction

endpackage

// File: rtl/so_txn_counter.sv
module so_txn_counter #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic cnt_zero,
  output logic cnt_full
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (inc && !dec) cnt <= cnt + 1'b1;
    else if (dec && !inc) cnt <= cnt - 1'b1;
  end

  assign cnt_zero = (cnt == '0);
  assign cnt_full = (cnt == CNT_MAX);

  // R9: the issuing side never pushes past the maximum
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_full && inc |-> dec);
  // R9: no response is counted against an empty counter
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_zero && dec |-> inc);

endmodule

// File: rtl/so_order_fsm.sv
module so_order_fsm
  import so_gate_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic              req_so,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic              mem_write,
  output logic              mem_nc,
  output logic              mem_shared,
  output logic              mem_xcross,
  input  logic              rsp_valid,
  output logic              barrier_done,
  output logic              mask_grant,
  input  logic              cnt_zero,
  input  logic              cnt_full,
  output logic              cnt_inc,
  output logic              cnt_dec
);
  gate_state_e st, st_nx;
  logic [ADDR_W-1:0] so_addr;
  logic [1:0]        so_size;
  logic              so_write;

  // named internal events
  logic is_acc, in_free, in_issue, norm_go, so_take, so_fire, so_done;

  assign is_acc   = (req_kind_e'(req_kind) == K_ACCESS);
  assign in_free  = (st == S_FREE);
  assign in_issue = (st == S_ISSUE);
  assign norm_go  = in_free && req_valid && is_acc && !req_so && !cnt_full;
  assign so_take  = in_free && req_valid && is_acc && req_so;
  assign so_fire  = in_issue && mem_ready;
  assign so_done  = (st == S_WAIT) && rsp_valid;

  assign cnt_inc = norm_go && mem_ready;
  assign cnt_dec = rsp_valid && (st != S_WAIT);

  always_comb begin
    req_ready = 1'b0;
    if (in_free) begin
      unique case (req_kind_e'(req_kind))
        K_ACCESS:  req_ready = req_so || (mem_ready && !cnt_full);
        K_BARRIER: req_ready = 1'b1;
        K_MASKUPD: req_ready = 1'b1;
        default:   req_ready = 1'b0;
      endcase
    end
  end

  assign barrier_done = in_free && req_valid && (req_kind_e'(req_kind) == K_BARRIER);
  assign mask_grant   = in_free && req_valid && (req_kind_e'(req_kind) == K_MASKUPD);

  assign mem_valid  = norm_go || in_issue;
  assign mem_addr   = in_issue ? so_addr  : req_addr;
  assign mem_size   = in_issue ? so_size  : req_size;
  assign mem_write  = in_issue ? so_write : req_write;
  assign mem_nc     = in_issue;
  assign mem_shared = in_issue;
  assign mem_xcross = crosses_page(mem_addr[11:0], mem_size);

  always_comb begin
    st_nx = st;
    unique case (st)
      S_FREE:  if (so_take)   st_nx = S_DRAIN;
      S_DRAIN: if (cnt_zero)  st_nx = S_ISSUE;
      S_ISSUE: if (mem_ready) st_nx = S_WAIT;
      S_WAIT:  if (rsp_valid) st_nx = S_FREE;
      default: st_nx = S_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_FREE;
    else        st <= st_nx;
  end

  always_ff @(posedge clk) begin
    if (so_take) begin
      so_addr  <= req_addr;
      so_size  <= req_size;
      so_write <= req_write;
    end
  end

  // R2: nothing leaves while earlier normal accesses are still open
  a_r2_drain_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DRAIN) |-> !mem_valid);
  // R3: the ordered access goes out only on an empty counter
  a_r3_issue_alone: assert property (@(posedge clk) disable iff (!rst_n)
    in_issue |-> cnt_zero);
  // R3: held steady until taken
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    in_issue && !mem_ready |=> mem_valid && mem_nc && $stable(mem_addr) && $stable(mem_size));
  // R3: presented once only
  a_r3_no_replay: assert property (@(posedge clk) disable iff (!rst_n)
    so_fire |=> !mem_valid);
  // R4: core stalled while ordered access pending
  a_r4_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_free |-> !req_ready && !barrier_done && !mask_grant);
  // R5: completion frees the gate next cycle
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    so_done |=> in_free);
  // R6 R7: grants never together
  a_r6_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({barrier_done, mask_grant, mem_valid}));

endmodule

// File: rtl/so_order_gate.sv
module so_order_gate #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic              req_so,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic              mem_write,
  output logic              mem_nc,
  output logic              mem_shared,
  output logic              mem_xcross,
  input  logic              rsp_valid,
  output logic              barrier_done,
  output logic              mask_grant
);
  logic cnt_zero, cnt_full, cnt_inc, cnt_dec;

  so_txn_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(cnt_inc), .dec(cnt_dec),
    .cnt_zero(cnt_zero), .cnt_full(cnt_full)
  );

  so_order_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_so(req_so), .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_write(mem_write), .mem_nc(mem_nc),
    .mem_shared(mem_shared), .mem_xcross(mem_xcross),
    .rsp_valid(rsp_valid), .barrier_done(barrier_done), .mask_grant(mask_grant),
    .cnt_zero(cnt_zero), .cnt_full(cnt_full), .cnt_inc(cnt_inc), .cnt_dec(cnt_dec)
  );

  // R10: a freshly reset gate presents nothing on its own
  a_r10_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !mem_nc);

endmodule

// File: tb/test_so_order_gate.sv
module test_so_order_gate;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 4;
  localparam int MAXC   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_so = 1'b0, req_write = 1'b0;
  logic [1:0] req_kind = 2'd0, req_size = 2'd0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic mem_ready = 1'b0, rsp_valid = 1'b0;
  logic req_ready, mem_valid, mem_write, mem_nc, mem_shared, mem_xcross;
  logic barrier_done, mask_grant;
  logic [ADDR_W-1:0] mem_addr;
  logic [1:0] mem_size;

  always #10 clk = ~clk;

  so_order_gate #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_so_order_gate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_so(req_so), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_write(mem_write), .mem_nc(mem_nc),
    .mem_shared(mem_shared), .mem_xcross(mem_xcross), .rsp_valid(rsp_valid),
    .barrier_done(barrier_done), .mask_grant(mask_grant)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit running = 1'b0, finished = 1'b0, took = 1'b0;
  int full_hits = 0, so_seen = 0, blocked_bar = 0;

  // reference model: phase 0 free, 1 waiting for drain, 2 offering, 3 awaiting reply
  int ph = 0, pend = 0;
  logic [ADDR_W-1:0] sv_addr;
  logic [1:0] sv_size;
  logic sv_write;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  function automatic bit page_cross(input logic [ADDR_W-1:0] a, input logic [1:0] s);
    int unsigned off, len;
    off = a % 4096;
    len = 1 << s;
    return (off + len) > 4096;
  endfunction

  // compare against the model away from the rising edge
  always @(negedge clk) begin
    if (rst_n && running) begin
      bit e_rdy, e_mv, e_bd, e_mg;
      logic [ADDR_W-1:0] e_a; logic [1:0] e_s; bit e_w, e_so;
      e_so = (ph == 2);
      e_mv = e_so || (ph == 0 && req_valid && req_kind == 2'd0 && !req_so && pend < MAXC);
      e_rdy = (ph == 0) && (req_kind == 2'd0 ? (req_so || (mem_ready && pend < MAXC))
                                            : (req_kind == 2'd1 || req_kind == 2'd2));
      e_bd = (ph == 0) && req_valid && req_kind == 2'd1;
      e_mg = (ph == 0) && req_valid && req_kind == 2'd2;
      if (req_valid) chk(req_ready == e_rdy, (ph == 0) ? "R1/R9 ready" : "R4 stall", req_ready, e_rdy);
      chk(mem_valid == e_mv, e_so ? "R3 offer" : "R2/R9 issue", mem_valid, e_mv);
      chk(barrier_done == e_bd, "R6 barrier", barrier_done, e_bd);
      chk(mask_grant == e_mg, "R7 mask", mask_grant, e_mg);
      if (e_mv && mem_valid) begin
        e_a = e_so ? sv_addr : req_addr;
        e_s = e_so ? sv_size : req_size;
        e_w = e_so ? sv_write : req_write;
        chk(mem_addr == e_a, e_so ? "R3 addr" : "R1 addr", mem_addr, e_a);
        chk(mem_size == e_s, e_so ? "R3 size" : "R1 size", mem_size, e_s);
        chk(mem_write == e_w, e_so ? "R3 dir" : "R1 dir", mem_write, e_w);
        chk(mem_nc == e_so && mem_shared == e_so, e_so ? "R3 attr" : "R1 attr",
            {mem_nc, mem_shared}, {e_so, e_so});
        chk(mem_xcross == page_cross(e_a, e_s), "R8 xcross", mem_xcross, page_cross(e_a, e_s));
      end
      if (ph == 0 && req_valid && req_kind == 2'd0 && !req_so && pend == MAXC) full_hits++;
      if (ph != 0 && req_valid && req_kind != 2'd0) blocked_bar++;
      took = req_valid && req_ready;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      ph = 0; pend = 0;
    end else if (running) begin
      int nph, npend;
      nph = ph; npend = pend;
      case (ph)
        0: if (req_valid && req_kind == 2'd0 && req_so) begin
             sv_addr = req_addr; sv_size = req_size; sv_write = req_write; nph = 1; so_seen++;
           end else if (req_valid && req_kind == 2'd0 && pend < MAXC && mem_ready) npend++;
        1: if (pend == 0) nph = 2;
        2: if (mem_ready) nph = 3;
        3: if (rsp_valid) nph = 0;
        default: nph = 0;
      endcase
      if (rsp_valid && ph != 3) npend--;
      ph = nph; pend = npend;
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000 && !finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic drive_cycle(input int slow);
    @(posedge clk); #1;
    if (!req_valid || took) begin
      int r;
      r = $urandom % 10;
      req_valid = ($urandom % 10) < 7;
      req_kind = (r < 7) ? 2'd0 : (r < 9 ? 2'd1 : 2'd2);
      req_so = (r < 7) && (($urandom % 5) == 0);
      req_write = $urandom % 2;
      req_size = $urandom % 4;
      req_addr = ($urandom % 2) ? {$urandom} : {$urandom % 16, 12'hFF8 + 12'($urandom % 8)};
    end
    took = 1'b0;
    mem_ready = ($urandom % 4) != 0;
    if (ph == 3) rsp_valid = ($urandom % 3) == 0;
    else rsp_valid = (pend > 0) && (($urandom % slow) == 0);
  endtask

  initial begin
    #5;
    // R10: reset state visible at the ports
    #20;
    chk(mem_valid == 1'b0, "R10 reset mem_valid", mem_valid, 0);
    chk(barrier_done == 1'b0 && mask_grant == 1'b0, "R10 reset grants", {barrier_done, mask_grant}, 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1; running = 1'b1;
    for (int i = 0; i < 6000; i++) drive_cycle(((i / 400) % 2) ? 12 : 1);
    // R10: reset while an ordered access awaits its reply
    while (ph != 3) drive_cycle(1);
    @(posedge clk); #1;
    rst_n = 1'b0; req_valid = 1'b0; rsp_valid = 1'b0; mem_ready = 1'b1;
    #2;
    chk(mem_valid == 1'b0 && mem_nc == 1'b0, "R10 drop in-flight", {mem_valid, mem_nc}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    req_valid = 1'b1; req_kind = 2'd1;
    #8;
    chk(barrier_done == 1'b1 && req_ready == 1'b1, "R10 free after reset", {barrier_done, req_ready}, 2'b11);
    for (int i = 0; i < 40; i++) begin
      drive_cycle(1);
      #8;
      if (mem_nc && ph != 2) chk(1'b0, "R10 no reissue", mem_nc, 0);
    end
    running = 1'b0;
    chk(full_hits > 0, "R9 counter saturation reached", full_hits, 1);
    chk(so_seen > 3, "R2 ordered accesses exercised", so_seen, 4);
    chk(blocked_bar > 0, "R6/R7 held request seen", blocked_bar, 1);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule